// File: doc/BRIEF.md
# Two-Wire Register-File Target

This block is a serial slave on a two-wire bus (SCL clock, SDA open-drain data) that gives byte access to a 64-entry, 8-bit register store laid out like a real-time clock. Position 0 holds sub-second counts, 1 to 7 hold seconds, minutes, century/hours, weekday, date, month and year, 8 is control and 9 is the watchdog setting. 10 to 15 hold alarm settings, 16 to 18 are spare, 19 sets the square-wave output and 20 to 63 are general-purpose RAM. The timekeeping and alarm functions are not part of this block. Here every entry is plain storage.

Both bus lines are sampled with a fast system clock through two-flop synchronizers. Bus START and STOP are found by edge detection. The block responds to the fixed 7-bit device address 0x68. A write transaction loads an internal pointer from its first data byte and stores the bytes after it. A read transaction streams bytes from the pointer. The pointer advances after every byte. A second port lets on-chip logic read and write the same store. A power-fail input aborts any transfer, clears the pointer and makes the block ignore the bus.

Top module: `twi_regfile_slave`

## Requirements
- R1: Only the address bytes 0xD0 (write) and 0xD1 (read) are acknowledged. After any other address byte the block leaves SDA released, including on later bytes, until the next START.
- R2: A START (SDA high-to-low while SCL high) restarts address reception from any state. A STOP (SDA low-to-high while SCL high) ends the transfer. After reset and after STOP, `sda_oe` is 0.
- R3: Bytes are received MSB first. After each accepted byte the block holds SDA low for the whole high phase of the ninth clock. `sda_oe` changes only while the synchronized SCL is low, except on power-fail.
- R4: In a write transaction the first byte after the address byte sets the pointer to its low 6 bits. Each later byte is stored at the pointer, and the pointer then increments.
- R5: In a read transaction the entry at the pointer is sent MSB first. After each byte the pointer increments, and an acknowledged byte is followed by the next entry, without limit.
- R6: The pointer wraps from 63 to 0 in both reads and writes.
- R7: When the master does not acknowledge a read byte, the block releases SDA and sends nothing more until the next START. The pointer keeps the incremented value.
- R8: While `pwr_fail` is 1, the transfer in progress is abandoned, the pointer is forced to 0, and no bus byte is acknowledged or stored. After `pwr_fail` returns to 0, a new START is required.
- R9: A repeated START keeps the pointer, so a write of the pointer followed by a repeated START and a read returns data from that pointer.
- R10: With `host_we` = 1, `host_wdata` is stored at `host_addr` on the clock edge. `host_rdata` shows the entry at `host_addr` one clock after the address is presented.
- R11: When a bus write and a host write hit the same entry on the same clock edge, the bus byte is kept. Writes to different entries on the same edge are both kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| pwr_fail | input | 1 | Power-fail abort, synchronous to clk |
| host_we | input | 1 | On-chip write strobe |
| host_addr | input | 6 | On-chip entry index |
| host_wdata | input | 8 | On-chip write byte |
| host_rdata | output | 8 | On-chip read byte, one clock after address |

## Verification
A bus byte store and an on-chip store can hit the register array on the same clock edge. The bus store lands on the fourth system-clock edge after SCL falls at the end of the eighth data bit. The bench times a host write to that edge, once to the same entry and once to the neighbouring entry. Both entries are then read back through the host port and compared with the expected rule: the bus byte is kept on a clash, and both bytes are kept when the entries differ. Power-fail arriving in the middle of a byte is also exercised. It is judged by the missing acknowledge, the unchanged storage and the read that follows from entry 0.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_TX,
    ST_TX_ACK
  } twi_state_e;

  localparam logic [6:0] DEV_ADDR_DEFAULT = 7'h68;
  localparam int         BYTE_W           = 8;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
      if (rst) pipe <= '1;
      else     pipe <= {pipe[STAGES-1:0], line_i[g]};
    end

    assign level_o[g] = pipe[STAGES-1];
    assign rise_o[g]  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall_o[g]  = ~pipe[STAGES-1] & pipe[STAGES];
  end

endmodule

// File: rtl/twi_reg_ram.sv
module twi_reg_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Port B (host) is written first, port A (bus) last: bus wins a clash.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

  p_bus_wins_r11: assert property (@(posedge clk)
    ($past(a_we) && $past(b_we) && $past(a_addr) == $past(b_addr))
      |-> mem[$past(a_addr)] == $past(a_wdata));

endmodule

// File: rtl/twi_target_fsm.sv
module twi_target_fsm
  import twi_pkg::*;
#(
  parameter int         AW       = 6,
  parameter logic [6:0] DEV_ADDR = DEV_ADDR_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pf,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata
);

  twi_state_e    st;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic [7:0]    tx;
  logic [7:0]    wd;
  logic [AW-1:0] ptr;
  logic [AW-1:0] wa;
  logic          rw;
  logic          oe;
  logic          we;
  logic          nack;
  logic          start_c;
  logic          stop_c;

  assign start_c = sda_fall & scl_lvl;
  assign stop_c  = sda_rise & scl_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      sh   <= '0;
      tx   <= '0;
      wd   <= '0;
      ptr  <= '0;
      wa   <= '0;
      rw   <= 1'b0;
      oe   <= 1'b0;
      we   <= 1'b0;
      nack <= 1'b0;
    end else begin
      we <= 1'b0;
      if (pf) begin
        st  <= ST_IDLE;
        ptr <= '0;
        oe  <= 1'b0;
        cnt <= '0;
      end else if (start_c) begin
        st  <= ST_DEV;
        cnt <= '0;
        oe  <= 1'b0;
      end else if (stop_c) begin
        st  <= ST_IDLE;
        oe  <= 1'b0;
      end else begin
        if (scl_rise) begin
          sh  <= {sh[6:0], sda_lvl};
          cnt <= cnt + 4'd1;
          if (st == ST_TX_ACK) nack <= sda_lvl;
        end
        if (scl_fall) begin
          case (st)
            ST_DEV: begin
              if (cnt == 4'd8) begin
                cnt <= '0;
                if (sh[7:1] == DEV_ADDR) begin
                  rw <= sh[0];
                  oe <= 1'b1;
                  st <= ST_DEV_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end
            end
            ST_DEV_ACK: begin
              cnt <= '0;
              if (rw) begin
                tx <= rd_data;
                oe <= ~rd_data[7];
                st <= ST_TX;
              end else begin
                oe <= 1'b0;
                st <= ST_PTR;
              end
            end
            ST_PTR: begin
              if (cnt == 4'd8) begin
                cnt <= '0;
                ptr <= sh[AW-1:0];
                oe  <= 1'b1;
                st  <= ST_PTR_ACK;
              end
            end
            ST_PTR_ACK, ST_WR_ACK: begin
              cnt <= '0;
              oe  <= 1'b0;
              st  <= ST_WR;
            end
            ST_WR: begin
              if (cnt == 4'd8) begin
                cnt <= '0;
                we  <= 1'b1;
                wa  <= ptr;
                wd  <= sh;
                ptr <= ptr + 1'b1;
                oe  <= 1'b1;
                st  <= ST_WR_ACK;
              end
            end
            ST_TX: begin
              if (cnt == 4'd8) begin
                cnt <= '0;
                oe  <= 1'b0;
                ptr <= ptr + 1'b1;
                st  <= ST_TX_ACK;
              end else begin
                tx <= {tx[6:0], 1'b0};
                oe <= ~tx[6];
              end
            end
            ST_TX_ACK: begin
              cnt <= '0;
              if (nack) begin
                st <= ST_IDLE;
              end else begin
                tx <= rd_data;
                oe <= ~rd_data[7];
                st <= ST_TX;
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign sda_oe    = oe;
  assign bus_we    = we;
  assign bus_addr  = we ? wa : ptr;
  assign bus_wdata = wd;

  p_idle_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !oe);

  p_start_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (start_c && !pf) |=> (st == ST_DEV && !oe));

  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(oe) && !$past(pf)) |-> !$past(scl_lvl));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    we |-> (ptr == wa + 1'b1));

  p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '1) |-> (ptr == '0));

  p_nack_release_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TX_ACK && scl_fall && nack && !pf && !start_c && !stop_c)
      |=> (st == ST_IDLE && !oe));

  p_pf_clear_r8: assert property (@(posedge clk) disable iff (rst)
    pf |=> (ptr == '0 && !oe && st == ST_IDLE));

  p_pf_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    $past(pf) |-> !we);

endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave
  import twi_pkg::*;
#(
  parameter int         ADDR_W      = 6,
  parameter logic [6:0] DEV_ADDR    = DEV_ADDR_DEFAULT,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              pwr_fail,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata
);

  localparam int IDX_SCL = 1;
  localparam int IDX_SDA = 0;

  logic [1:0]        lvl;
  logic [1:0]        rise;
  logic [1:0]        fall;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [BYTE_W-1:0] bus_wdata;
  logic [BYTE_W-1:0] bus_rdata;

  twi_line_sync #(
    .LINES  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .line_i  ({scl_i, sda_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  twi_target_fsm #(
    .AW       (ADDR_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .pf        (pwr_fail),
    .scl_lvl   (lvl[IDX_SCL]),
    .scl_rise  (rise[IDX_SCL]),
    .scl_fall  (fall[IDX_SCL]),
    .sda_lvl   (lvl[IDX_SDA]),
    .sda_rise  (rise[IDX_SDA]),
    .sda_fall  (fall[IDX_SDA]),
    .rd_data   (bus_rdata),
    .sda_oe    (sda_oe),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
  );

  twi_reg_ram #(
    .AW (ADDR_W),
    .DW (BYTE_W)
  ) u_ram (
    .clk     (clk),
    .a_we    (bus_we),
    .a_addr  (bus_addr),
    .a_wdata (bus_wdata),
    .a_rdata (bus_rdata),
    .b_we    (host_we),
    .b_addr  (host_addr),
    .b_wdata (host_wdata),
    .b_rdata (host_rdata)
  );

endmodule

// File: tb/twi_regfile_slave_test.sv
module twi_regfile_slave_test;

  localparam int Q = 10;

  typedef struct {
    string req;
    int    val;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       pwr_fail = 1'b0;
  logic       host_we = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       sda_oe;
  wire        sda_line = m_sda & ~sda_oe;

  logic [7:0] model [64];
  item_t      exp_q [$];
  int         act_q [$];
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 0;

  bit         coll_en = 0;
  logic [5:0] coll_addr = '0;
  logic [7:0] coll_data = '0;

  always #4 clk = ~clk;

  twi_regfile_slave uut (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe     (sda_oe),
    .pwr_fail   (pwr_fail),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_item(input string req, input int v);
    exp_q.push_back('{req, v});
  endtask

  task automatic observe(input int v);
    act_q.push_back(v);
  endtask

  // monitor: pops expected/actual pairs and compares
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        item_t e;
        int    a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_cmp++;
        if (a != e.val) begin
          n_bad++;
          $display("FAIL %s: actual %0h expected %0h", e.req, a, e.val);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic clk_bit(input logic d, output logic s);
    wait_cyc(Q);
    m_sda = d;
    wait_cyc(Q);
    scl = 1'b1;
    wait_cyc(Q);
    s = sda_line;
    wait_cyc(Q);
    scl = 1'b0;
  endtask

  task automatic bus_start();
    wait_cyc(Q);
    m_sda = 1'b1;
    wait_cyc(Q);
    scl = 1'b1;
    wait_cyc(Q);
    m_sda = 1'b0;
    wait_cyc(Q);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_cyc(Q);
    m_sda = 1'b0;
    wait_cyc(Q);
    scl = 1'b1;
    wait_cyc(Q);
    m_sda = 1'b1;
    wait_cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    if (coll_en) begin
      fork
        begin
          repeat (3) @(posedge clk);
          #1;
          host_we    = 1'b1;
          host_addr  = coll_addr;
          host_wdata = coll_data;
          @(posedge clk);
          #1;
          host_we = 1'b0;
        end
      join_none
    end
    clk_bit(1'b1, ack);
    m_sda = 1'b1;
  endtask

  task automatic recv_byte(input logic mnack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(mnack, s);
    m_sda = 1'b1;
  endtask

  task automatic host_write(input logic [5:0] a, input logic [7:0] d);
    host_we    = 1'b1;
    host_addr  = a;
    host_wdata = d;
    wait_cyc(1);
    host_we = 1'b0;
  endtask

  task automatic host_check(input string req, input logic [5:0] a);
    host_addr = a;
    wait_cyc(1);
    expect_item(req, int'(model[a]));
    observe(int'(host_rdata));
  endtask

  task automatic wr_byte_chk(input string req, input logic [7:0] b, input logic exp_ack);
    logic ack;
    expect_item(req, int'(exp_ack));
    send_byte(b, ack);
    observe(int'(ack));
  endtask

  task automatic rd_byte_chk(input string req, input logic mnack, input logic [7:0] e);
    logic [7:0] got;
    expect_item(req, int'(e));
    recv_byte(mnack, got);
    observe(int'(got));
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    // R2: released after reset
    expect_item("R2 reset sda_oe", 0);
    observe(int'(sda_oe));

    // R10: host port fill and read-back
    for (int i = 0; i < 64; i++) begin
      model[i] = 8'((i * 37 + 11) & 8'hFF);
      host_write(6'(i), model[i]);
    end
    host_check("R10 host read 0", 6'd0);
    host_check("R10 host read 19", 6'd19);
    host_check("R10 host read 63", 6'd63);

    // R4, R3: pointer load then two stores
    bus_start();
    wr_byte_chk("R1 ack D0", 8'hD0, 1'b0);
    wr_byte_chk("R4 ack pointer", 8'h05, 1'b0);
    wr_byte_chk("R3 ack data0", 8'hA5, 1'b0);
    wr_byte_chk("R3 ack data1", 8'h3C, 1'b0);
    bus_stop();
    model[5] = 8'hA5;
    model[6] = 8'h3C;
    host_check("R4 stored at 5", 6'd5);
    host_check("R4 stored at 6", 6'd6);
    expect_item("R2 released after STOP", 0);
    observe(int'(sda_oe));

    // R1: foreign address is ignored together with its data
    bus_start();
    wr_byte_chk("R1 nack A0", 8'hA0, 1'b1);
    wr_byte_chk("R1 nack after foreign", 8'h07, 1'b1);
    wr_byte_chk("R1 nack after foreign 2", 8'h99, 1'b1);
    bus_stop();
    host_check("R1 entry 7 untouched", 6'd7);

    // R5, R9: pointer write, repeated START, sequential read
    bus_start();
    wr_byte_chk("R9 ack D0", 8'hD0, 1'b0);
    wr_byte_chk("R9 ack pointer 4", 8'h04, 1'b0);
    bus_start();
    wr_byte_chk("R9 ack D1", 8'hD1, 1'b0);
    rd_byte_chk("R9 read entry 4", 1'b0, model[4]);
    rd_byte_chk("R5 read entry 5", 1'b0, model[5]);
    rd_byte_chk("R5 read entry 6", 1'b1, model[6]);
    bus_stop();

    // R6: write wrap 62 -> 63 -> 0 (pointer byte has spare high bits set)
    bus_start();
    wr_byte_chk("R6 ack D0", 8'hD0, 1'b0);
    wr_byte_chk("R6 ack pointer 62", 8'hFE, 1'b0);
    wr_byte_chk("R6 ack d62", 8'h11, 1'b0);
    wr_byte_chk("R6 ack d63", 8'h22, 1'b0);
    wr_byte_chk("R6 ack d0", 8'h33, 1'b0);
    bus_stop();
    model[62] = 8'h11;
    model[63] = 8'h22;
    model[0]  = 8'h33;
    host_check("R6 entry 62", 6'd62);
    host_check("R6 entry 63", 6'd63);
    host_check("R6 wrapped entry 0", 6'd0);

    // R7: pointer now 1; master NACK stops transmission
    bus_start();
    wr_byte_chk("R7 ack D1", 8'hD1, 1'b0);
    rd_byte_chk("R7 read entry 1", 1'b1, model[1]);
    rd_byte_chk("R7 silent after NACK", 1'b1, 8'hFF);
    bus_stop();
    bus_start();
    wr_byte_chk("R7 ack D1 again", 8'hD1, 1'b0);
    rd_byte_chk("R7 pointer advanced", 1'b0, model[2]);
    rd_byte_chk("R6 read continues", 1'b1, model[3]);
    bus_stop();

    // R8: power fail in the middle of a write
    bus_start();
    wr_byte_chk("R8 ack D0", 8'hD0, 1'b0);
    wr_byte_chk("R8 ack pointer 16", 8'h10, 1'b0);
    wr_byte_chk("R8 ack d16", 8'h77, 1'b0);
    model[16] = 8'h77;
    pwr_fail = 1'b1;
    wr_byte_chk("R8 no ack during fail", 8'h88, 1'b1);
    pwr_fail = 1'b0;
    wr_byte_chk("R8 no ack without START", 8'h99, 1'b1);
    bus_stop();
    host_check("R8 entry 16 written", 6'd16);
    host_check("R8 entry 17 untouched", 6'd17);
    host_check("R8 entry 18 untouched", 6'd18);
    bus_start();
    wr_byte_chk("R8 ack D1", 8'hD1, 1'b0);
    rd_byte_chk("R8 pointer reset to 0", 1'b1, model[0]);
    bus_stop();

    // R11: bus store and host store on the same edge
    bus_start();
    wr_byte_chk("R11 ack D0", 8'hD0, 1'b0);
    wr_byte_chk("R11 ack pointer 48", 8'h30, 1'b0);
    coll_en   = 1;
    coll_addr = 6'h30;
    coll_data = 8'h5A;
    wr_byte_chk("R11 ack clash byte", 8'hC3, 1'b0);
    coll_addr = 6'h32;
    coll_data = 8'h6B;
    wr_byte_chk("R11 ack split byte", 8'h3C, 1'b0);
    coll_en = 0;
    bus_stop();
    model[48] = 8'hC3;
    model[49] = 8'h3C;
    model[50] = 8'h6B;
    host_check("R11 bus wins same entry", 6'd48);
    host_check("R11 bus byte other entry", 6'd49);
    host_check("R11 host byte other entry", 6'd50);

    wait_cyc(5);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0 left", exp_q.size() + act_q.size());
    end
    finish_run();
  end

endmodule